// File: doc/BRIEF.md
# PHY Discovery and Link-Wait Sequencer

This block finds an Ethernet PHY on the management bus and then waits for its link to come up, with no software involved. It drives read requests to an MDIO master through a single-cycle request and done handshake. The serial management protocol itself is handled by that master. One `start` pulse runs the whole sequence. The block scans PHY addresses upward from 0 and reads the first identifier register at each address. It stops at the first address that answers with anything other than all-ones, then reads the second identifier register there. A scan that finds nothing is repeated a bounded number of times, with a fixed pause before each repeat.

After a PHY is found, the sequencer reads the basic status register again and again, with a shorter pause between reads. It stops when both the auto-negotiation-complete bit and the link bit are set, or when its poll budget runs out. The results stay on the outputs until the next discovery: the chosen address, the 32-bit ID, whether that ID matches a configured known value, and flags for no PHY found, link up and link timeout. Once an address has been identified, later start pulses return at once with the cached result and do not rescan.

All pause lengths come from one shared down-counter. Its load values are derived from the `CLK_HZ` parameter: the pause between scan passes is `CLK_HZ/100` cycles (10 ms) and the pause between status polls is `CLK_HZ/2000` cycles (500 µs).

Top module: `phy_probe_seq`

## Requirements
- R1: Each identifier scan reads management register 2 at addresses 0, 1, 2 and so on upward, up to 31. Each request is a one-cycle `mdio_req` pulse, and `mdio_reg` is always 1, 2 or 3 during a request.
- R2: A register-2 value of 0xFFFF means no PHY is at that address. The first other value (0x0000 included) ends the scan at that address, and no further register-2 reads follow.
- R3: Register 3 is then read at the selected address, and `phy_id` becomes {register-2 value, register-3 value}, with register 2 in bits 31:16.
- R4: A pass that reaches address 31 with no PHY starts a new pass from address 0, up to `MAX_PASSES` passes in total. At least `CLK_HZ/100` cycles separate the last request of one pass from the first request of the next.
- R5: When every pass fails, `not_found` is 1, `phy_addr` is 0x1F and `phy_valid` is 0.
- R6: A `start` while `phy_valid` is 1 raises `done` in the next cycle, issues no management request, and leaves all result outputs unchanged.
- R7: After identification, register 1 is polled until a read has bit 5 (auto-negotiation complete) and bit 2 (link) both set. `link_up` is then 1. A read with only one of the two bits set does not end polling.
- R8: At least `CLK_HZ/2000` cycles separate consecutive polls. If `MAX_POLLS` reads go by without success, `link_timeout` is 1 and the address, ID and `phy_valid` remain reported. A success on the final allowed read counts as link up, not as a timeout. `link_up` and `link_timeout` are never both 1.
- R9: `id_known` is 1 exactly when `phy_valid` is 1 and `phy_id` equals `KNOWN_ID` (default 0x0022561B).
- R10: After reset, `busy`, `done`, `mdio_req`, `phy_valid`, `not_found`, `link_up` and `link_timeout` are 0, and `phy_addr` is 0x1F. No request is issued while `busy` is 0.
- R11: Each accepted `start` ends with `done` high for exactly one cycle, and `busy` is high in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin discovery, or return the cached result |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| mdio_req | output | 1 | One-cycle read request to the management master |
| mdio_phy | output | 5 | PHY address of the request |
| mdio_reg | output | 5 | Register address of the request |
| mdio_done | input | 1 | One-cycle read completion from the master |
| mdio_rdata | input | 16 | Read data, valid with `mdio_done` |
| phy_addr | output | 5 | Selected PHY address, 0x1F when none |
| phy_valid | output | 1 | A PHY has been identified |
| phy_id | output | 32 | Identifier {reg2, reg3} |
| id_known | output | 1 | Identifier equals `KNOWN_ID` |
| not_found | output | 1 | All scan passes failed |
| link_up | output | 1 | Status poll saw auto-negotiation complete and link |
| link_timeout | output | 1 | Poll budget exhausted without link |

## Verification
The poll budget and the link-good test can both resolve on the same status read. When the final allowed read is also the first one that reports both bits, the block must choose between success and timeout. The bench sets up this case with a model PHY whose link comes up on exactly poll `MAX_POLLS`. It then expects `link_up` high and `link_timeout` low, with exactly `MAX_POLLS` status reads. A second collision is a `start` that arrives while the result is cached. The bench judges that case by counting zero management requests and seeing `done` in the following cycle.

// File: rtl/phy_probe_pkg.sv
// Shared constants and types for the PHY discovery sequencer.
// Assumes the standard management register layout: register 1 holds
// status, registers 2 and 3 hold the identifier halves.
package phy_probe_pkg;

    localparam int ADDR_W = 5;
    localparam int REG_W  = 5;
    localparam int DATA_W = 16;
    localparam int ID_W   = 2 * DATA_W;

    localparam logic [REG_W-1:0]  REG_STATUS = REG_W'(1);
    localparam logic [REG_W-1:0]  REG_IDHI   = REG_W'(2);
    localparam logic [REG_W-1:0]  REG_IDLO   = REG_W'(3);
    localparam int                BIT_ANEG   = 5;
    localparam int                BIT_LINK   = 2;
    localparam logic [DATA_W-1:0] NO_PHY     = '1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_RESP,
        ST_PAUSE
    } seq_state_t;

    typedef enum logic [1:0] {
        STEP_IDHI,
        STEP_IDLO,
        STEP_POLL
    } seq_step_t;

endpackage

// File: rtl/phy_wait_timer.sv
// Single shared down-counter for all pauses of the sequencer.
// Assumes load_val >= 1; busy stays high from the cycle after a load
// until the count has drained to zero.
module phy_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);

    logic [CNT_W-1:0] remain;

    // Load a new pause length or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // Pause is in progress while any count remains.
    always_comb begin
        busy = (remain != '0);
    end

endmodule

// File: rtl/phy_id_match.sv
// Compares the discovered identifier with a configured known value.
// Assumes id is only meaningful while valid is high.
module phy_id_match #(
    parameter int              ID_W  = 32,
    parameter logic [ID_W-1:0] KNOWN = 32'h0022_561B
) (
    input  logic            valid,
    input  logic [ID_W-1:0] id,
    output logic            known
);

    // Flag a match only for a valid identifier.
    always_comb begin
        known = valid && (id == KNOWN);
    end

endmodule

// File: rtl/phy_probe_ctrl.sv
// Sequencing core: address scan with retries, identifier capture,
// cached-result shortcut, and status polling with a bounded budget.
// Assumes the management master returns exactly one mdio_done per
// mdio_req and that the pause timer reports busy the cycle after a load.
module phy_probe_ctrl
    import phy_probe_pkg::*;
#(
    parameter int MAX_PASSES = 11,
    parameter int MAX_POLLS  = 16,
    parameter int PASS_CYC   = 500_000,
    parameter int POLL_CYC   = 25_000,
    parameter int TMR_W      = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              mdio_req,
    output logic [ADDR_W-1:0] mdio_phy,
    output logic [REG_W-1:0]  mdio_reg,
    input  logic              mdio_done,
    input  logic [DATA_W-1:0] mdio_rdata,
    output logic              tmr_load,
    output logic [TMR_W-1:0]  tmr_val,
    input  logic              tmr_busy,
    output logic [ADDR_W-1:0] phy_addr,
    output logic              phy_valid,
    output logic [ID_W-1:0]   phy_id,
    output logic              not_found,
    output logic              link_up,
    output logic              link_timeout
);

    localparam int PASS_W = $clog2(MAX_PASSES + 1);
    localparam int POLL_W = $clog2(MAX_POLLS + 1);
    localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(MAX_PASSES - 1);
    localparam logic [POLL_W-1:0] LAST_POLL = POLL_W'(MAX_POLLS - 1);
    localparam logic [ADDR_W-1:0] TOP_ADDR  = '1;

    seq_state_t        state;
    seq_step_t         step;
    logic [ADDR_W-1:0] scan_addr;
    logic [PASS_W-1:0] pass_cnt;
    logic [POLL_W-1:0] poll_cnt;
    logic [DATA_W-1:0] id_hi;

    logic rsp_now;
    logic absent;
    logic pass_end;
    logic link_good;
    logic retry_pass;
    logic retry_poll;

    // Decode the response arriving in this cycle.
    always_comb begin
        rsp_now    = (state == ST_RESP) && mdio_done;
        absent     = (mdio_rdata == NO_PHY);
        pass_end   = absent && (scan_addr == TOP_ADDR);
        link_good  = mdio_rdata[BIT_ANEG] && mdio_rdata[BIT_LINK];
        retry_pass = rsp_now && (step == STEP_IDHI) && pass_end && (pass_cnt != LAST_PASS);
        retry_poll = rsp_now && (step == STEP_POLL) && !link_good && (poll_cnt != LAST_POLL);
    end

    // Start the shared pause timer for whichever wait follows.
    always_comb begin
        tmr_load = retry_pass || retry_poll;
        tmr_val  = (step == STEP_POLL) ? TMR_W'(POLL_CYC) : TMR_W'(PASS_CYC);
    end

    // Drive the request fields from the current step.
    always_comb begin
        busy     = (state != ST_IDLE);
        mdio_req = (state == ST_ISSUE);
        unique case (step)
            STEP_IDHI: begin
                mdio_phy = scan_addr;
                mdio_reg = REG_IDHI;
            end
            STEP_IDLO: begin
                mdio_phy = scan_addr;
                mdio_reg = REG_IDLO;
            end
            default: begin
                mdio_phy = phy_addr;
                mdio_reg = REG_STATUS;
            end
        endcase
    end

    // Main sequence state, counters and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            step         <= STEP_IDHI;
            scan_addr    <= '0;
            pass_cnt     <= '0;
            poll_cnt     <= '0;
            id_hi        <= '0;
            done         <= 1'b0;
            phy_addr     <= TOP_ADDR;
            phy_valid    <= 1'b0;
            phy_id       <= '0;
            not_found    <= 1'b0;
            link_up      <= 1'b0;
            link_timeout <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (phy_valid) begin
                            done <= 1'b1;
                        end else begin
                            step         <= STEP_IDHI;
                            scan_addr    <= '0;
                            pass_cnt     <= '0;
                            poll_cnt     <= '0;
                            not_found    <= 1'b0;
                            link_up      <= 1'b0;
                            link_timeout <= 1'b0;
                            state        <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    state <= ST_RESP;
                end
                ST_RESP: begin
                    if (mdio_done) begin
                        unique case (step)
                            STEP_IDHI: begin
                                if (!absent) begin
                                    id_hi <= mdio_rdata;
                                    step  <= STEP_IDLO;
                                    state <= ST_ISSUE;
                                end else if (!pass_end) begin
                                    scan_addr <= scan_addr + 1'b1;
                                    state     <= ST_ISSUE;
                                end else if (retry_pass) begin
                                    scan_addr <= '0;
                                    pass_cnt  <= pass_cnt + 1'b1;
                                    state     <= ST_PAUSE;
                                end else begin
                                    not_found <= 1'b1;
                                    phy_addr  <= TOP_ADDR;
                                    done      <= 1'b1;
                                    state     <= ST_IDLE;
                                end
                            end
                            STEP_IDLO: begin
                                phy_id    <= {id_hi, mdio_rdata};
                                phy_addr  <= scan_addr;
                                phy_valid <= 1'b1;
                                poll_cnt  <= '0;
                                step      <= STEP_POLL;
                                state     <= ST_ISSUE;
                            end
                            default: begin
                                poll_cnt <= poll_cnt + 1'b1;
                                if (link_good) begin
                                    link_up <= 1'b1;
                                    done    <= 1'b1;
                                    state   <= ST_IDLE;
                                end else if (retry_poll) begin
                                    state <= ST_PAUSE;
                                end else begin
                                    link_timeout <= 1'b1;
                                    done         <= 1'b1;
                                    state        <= ST_IDLE;
                                end
                            end
                        endcase
                    end
                end
                default: begin
                    if (!tmr_busy) begin
                        state <= ST_ISSUE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/phy_probe_seq.sv
// Top of the PHY discovery and link-wait sequencer. Derives pause
// lengths from CLK_HZ and wires the sequencing core, the shared pause
// timer and the identifier comparator together.
// Assumes CLK_HZ is at least 2000 so that every pause lasts one or more cycles.
module phy_probe_seq
    import phy_probe_pkg::*;
#(
    parameter int              CLK_HZ     = 50_000_000,
    parameter int              MAX_PASSES = 11,
    parameter int              MAX_POLLS  = 16,
    parameter logic [ID_W-1:0] KNOWN_ID   = 32'h0022_561B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              mdio_req,
    output logic [ADDR_W-1:0] mdio_phy,
    output logic [REG_W-1:0]  mdio_reg,
    input  logic              mdio_done,
    input  logic [DATA_W-1:0] mdio_rdata,
    output logic [ADDR_W-1:0] phy_addr,
    output logic              phy_valid,
    output logic [ID_W-1:0]   phy_id,
    output logic              id_known,
    output logic              not_found,
    output logic              link_up,
    output logic              link_timeout
);

    localparam int PASS_RAW = CLK_HZ / 100;
    localparam int POLL_RAW = CLK_HZ / 2000;
    localparam int PASS_CYC = (PASS_RAW < 1) ? 1 : PASS_RAW;
    localparam int POLL_CYC = (POLL_RAW < 1) ? 1 : POLL_RAW;
    localparam int TMR_W    = $clog2(PASS_CYC + 1);

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_busy;

    phy_probe_ctrl #(
        .MAX_PASSES (MAX_PASSES),
        .MAX_POLLS  (MAX_POLLS),
        .PASS_CYC   (PASS_CYC),
        .POLL_CYC   (POLL_CYC),
        .TMR_W      (TMR_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .busy         (busy),
        .done         (done),
        .mdio_req     (mdio_req),
        .mdio_phy     (mdio_phy),
        .mdio_reg     (mdio_reg),
        .mdio_done    (mdio_done),
        .mdio_rdata   (mdio_rdata),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .tmr_busy     (tmr_busy),
        .phy_addr     (phy_addr),
        .phy_valid    (phy_valid),
        .phy_id       (phy_id),
        .not_found    (not_found),
        .link_up      (link_up),
        .link_timeout (link_timeout)
    );

    phy_wait_timer #(
        .CNT_W (TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .busy     (tmr_busy)
    );

    phy_id_match #(
        .ID_W  (ID_W),
        .KNOWN (KNOWN_ID)
    ) u_match (
        .valid (phy_valid),
        .id    (phy_id),
        .known (id_known)
    );

endmodule

// File: rtl/phy_probe_seq_chk.sv
// Property checker for the PHY discovery sequencer, bound to its top.
// Observes ports only.
module phy_probe_seq_chk #(
    parameter int ADDR_W = 5,
    parameter int REG_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              mdio_req,
    input logic [REG_W-1:0]  mdio_reg,
    input logic [ADDR_W-1:0] phy_addr,
    input logic              phy_valid,
    input logic              id_known,
    input logic              not_found,
    input logic              link_up,
    input logic              link_timeout
);

    assert_req_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_req |=> !mdio_req);

    assert_req_reg_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_req |-> (mdio_reg == REG_W'(1) || mdio_reg == REG_W'(2) || mdio_reg == REG_W'(3)));

    assert_absent_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        not_found |-> (!phy_valid && phy_addr == '1));

    assert_cached_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && phy_valid) |=> (done && !mdio_req && phy_valid));

    assert_link_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(link_up && link_timeout));

    assert_known_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        id_known |-> phy_valid);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_req);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind phy_probe_seq phy_probe_seq_chk #(
    .ADDR_W (phy_probe_pkg::ADDR_W),
    .REG_W  (phy_probe_pkg::REG_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .mdio_req     (mdio_req),
    .mdio_reg     (mdio_reg),
    .phy_addr     (phy_addr),
    .phy_valid    (phy_valid),
    .id_known     (id_known),
    .not_found    (not_found),
    .link_up      (link_up),
    .link_timeout (link_timeout)
);

// File: tb/phy_probe_seq_tb.sv
// Directed bench: a behavioural management-bus model answers reads,
// and one task per scenario checks the sequencer's results.
module phy_probe_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 20000;
    localparam int PASSES     = 11;
    localparam int POLLS      = 6;
    localparam int PASS_WAIT  = CLK_HZ / 100;
    localparam int POLL_WAIT  = CLK_HZ / 2000;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy, done, mdio_req;
    logic [4:0]  mdio_phy, mdio_reg;
    logic        mdio_done = 1'b0;
    logic [15:0] mdio_rdata = '0;
    logic [4:0]  phy_addr;
    logic        phy_valid;
    logic [31:0] phy_id;
    logic        id_known, not_found, link_up, link_timeout;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    // Model configuration and statistics
    int          m_addr   = -1;
    int          m_appear = 1;
    int          m_link   = 0;
    logic [15:0] m_id1    = '0;
    logic [15:0] m_id2    = '0;
    int n_req, n_idhi, n_idlo, n_stat, n_pass, scan_err, lo_err;
    int exp_addr, last_req_cyc, pass_gap_min, poll_gap_min;

    phy_probe_seq #(
        .CLK_HZ     (CLK_HZ),
        .MAX_PASSES (PASSES),
        .MAX_POLLS  (POLLS)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .busy         (busy),
        .done         (done),
        .mdio_req     (mdio_req),
        .mdio_phy     (mdio_phy),
        .mdio_reg     (mdio_reg),
        .mdio_done    (mdio_done),
        .mdio_rdata   (mdio_rdata),
        .phy_addr     (phy_addr),
        .phy_valid    (phy_valid),
        .phy_id       (phy_id),
        .id_known     (id_known),
        .not_found    (not_found),
        .link_up      (link_up),
        .link_timeout (link_timeout)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cyc = cyc + 1;
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
    end

    // Management-bus model: two cycles of latency per read.
    initial begin
        int          lat;
        logic [15:0] resp;
        lat = 0;
        resp = '0;
        forever begin
            @(posedge clk);
            mdio_done <= 1'b0;
            if (lat > 0) begin
                lat = lat - 1;
                if (lat == 0) begin
                    mdio_done  <= 1'b1;
                    mdio_rdata <= resp;
                end
            end else if (mdio_req) begin
                n_req++;
                lat = 2;
                if (mdio_reg == 5'd2) begin
                    if (mdio_phy == 5'd0) begin
                        n_pass++;
                        if (n_pass > 1 && (cyc - last_req_cyc) < pass_gap_min)
                            pass_gap_min = cyc - last_req_cyc;
                    end
                    if (int'(mdio_phy) != exp_addr) scan_err++;
                    exp_addr = (int'(mdio_phy) + 1) % 32;
                    n_idhi++;
                    resp = (int'(mdio_phy) == m_addr && n_pass >= m_appear) ? m_id1 : 16'hFFFF;
                end else if (mdio_reg == 5'd3) begin
                    n_idlo++;
                    if (int'(mdio_phy) != m_addr) lo_err++;
                    resp = m_id2;
                end else begin
                    n_stat++;
                    if (n_stat > 1 && (cyc - last_req_cyc) < poll_gap_min)
                        poll_gap_min = cyc - last_req_cyc;
                    if (m_link != 0 && n_stat >= m_link) resp = 16'h782C;
                    else if (n_stat % 2 == 1)            resp = 16'h7829;
                    else                                  resp = 16'h780D;
                end
                last_req_cyc = cyc;
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic chk_ge(input string what, input int act, input int lim);
        n_chk++;
        if (act < lim) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected>=%0d", what, act, lim);
        end
    endtask

    task automatic clear_stats();
        n_req = 0; n_idhi = 0; n_idlo = 0; n_stat = 0; n_pass = 0;
        scan_err = 0; lo_err = 0; exp_addr = 0; last_req_cyc = 0;
        pass_gap_min = 1 << 30; poll_gap_min = 1 << 30;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Pulse start and return cycles waited for done (sampled at negedges).
    task automatic run_start(output int waited);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (!done && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        chk("R11 done seen", {31'b0, done}, 32'h1);
        @(negedge clk);
        chk("R11 done one cycle", {31'b0, done}, 32'h0);
        chk("R11 busy low after done", {31'b0, busy}, 32'h0);
    endtask

    task automatic t_reset();
        clear_stats();
        do_reset();
        chk("R10 busy", {31'b0, busy}, 0);
        chk("R10 done", {31'b0, done}, 0);
        chk("R10 mdio_req", {31'b0, mdio_req}, 0);
        chk("R10 phy_valid", {31'b0, phy_valid}, 0);
        chk("R10 flags", {29'b0, not_found, link_up, link_timeout}, 0);
        chk("R10 phy_addr", {27'b0, phy_addr}, 32'h1F);
        repeat (5) @(negedge clk);
        chk("R10 no request while idle", n_req, 0);
    endtask

    task automatic t_found_known();
        int w;
        m_addr = 5; m_appear = 1; m_id1 = 16'h0022; m_id2 = 16'h561B; m_link = 3;
        clear_stats();
        do_reset();
        run_start(w);
        chk("R1 ascending scan order", scan_err, 0);
        chk("R2 scan stops at first responder", n_idhi, 6);
        chk("R3 one reg3 read at found address", {n_idlo[15:0], lo_err[15:0]}, 32'h0001_0000);
        chk("R3 phy_id", phy_id, 32'h0022_561B);
        chk("R2 phy_addr", {27'b0, phy_addr}, 5);
        chk("R9 id_known", {31'b0, id_known}, 1);
        chk("R7 polls until both bits", n_stat, 3);
        chk("R7 link_up", {30'b0, link_up, link_timeout}, 32'h2);
        chk_ge("R8 poll spacing", poll_gap_min, POLL_WAIT);
    endtask

    task automatic t_cached();
        int w;
        clear_stats();
        run_start(w);
        chk("R6 immediate done", w, 0);
        chk("R6 no rescan requests", n_req, 0);
        chk("R6 cached address", {27'b0, phy_addr}, 5);
        chk("R6 cached id", phy_id, 32'h0022_561B);
        chk("R6 cached flags", {28'b0, phy_valid, not_found, link_up, link_timeout}, 32'hA);
    endtask

    task automatic t_unknown_timeout();
        int w;
        m_addr = 0; m_appear = 1; m_id1 = 16'h0000; m_id2 = 16'h1234; m_link = 0;
        clear_stats();
        do_reset();
        run_start(w);
        chk("R2 value 0x0000 counts as present", n_idhi, 1);
        chk("R3 id with zero upper half", phy_id, 32'h0000_1234);
        chk("R9 unknown id", {31'b0, id_known}, 0);
        chk("R8 poll budget used", n_stat, POLLS);
        chk("R8 timeout flags", {30'b0, link_up, link_timeout}, 32'h1);
        chk("R8 result kept on timeout", {26'b0, phy_valid, phy_addr}, 32'h20);
        chk_ge("R8 poll spacing", poll_gap_min, POLL_WAIT);
    endtask

    task automatic t_last_poll();
        int w;
        m_addr = 0; m_appear = 1; m_id1 = 16'h0022; m_id2 = 16'h561B; m_link = POLLS;
        clear_stats();
        do_reset();
        run_start(w);
        chk("R8 final-read success polls", n_stat, POLLS);
        chk("R8 final-read success wins", {30'b0, link_up, link_timeout}, 32'h2);
    endtask

    task automatic t_none();
        int w;
        m_addr = -1; m_appear = 1; m_link = 0;
        clear_stats();
        do_reset();
        run_start(w);
        chk("R4 pass count", n_pass, PASSES);
        chk("R4 total scan reads", n_idhi, 32 * PASSES);
        chk("R1 ascending scan order", scan_err, 0);
        chk_ge("R4 pause between passes", pass_gap_min, PASS_WAIT);
        chk("R5 not_found", {31'b0, not_found}, 1);
        chk("R5 phy_addr", {27'b0, phy_addr}, 32'h1F);
        chk("R5 phy_valid", {31'b0, phy_valid}, 0);
        chk("R5 no reg3 or status reads", n_idlo + n_stat, 0);
    endtask

    task automatic t_late_top();
        int w;
        m_addr = 31; m_appear = 3; m_id1 = 16'h2000; m_id2 = 16'h5C90; m_link = 2;
        clear_stats();
        do_reset();
        run_start(w);
        chk("R4 found on third pass", n_pass, 3);
        chk("R4 scan reads across passes", n_idhi, 96);
        chk("R2 top address selected", {27'b0, phy_addr}, 31);
        chk("R3 phy_id", phy_id, 32'h2000_5C90);
        chk("R5 not_found clear", {31'b0, not_found}, 0);
        chk("R7 link after one partial read", {30'b0, link_up, link_timeout}, 32'h2);
    endtask

    initial begin
        t_reset();
        t_found_known();
        t_cached();
        t_unknown_timeout();
        t_last_poll();
        t_none();
        t_late_top();
        summary();
    end

endmodule